// File: doc/BRIEF.md
# Read-Side Long-Word Width Matcher

This block sits on the read side of a FIFO whose storage array only ever holds whole 36-bit long words. It turns the long word at the head of the FIFO into what a narrower reader consumes. Depending on the port size chosen, the reader sees one 36-bit long word, two 18-bit words or four 9-bit bytes. For the two narrow sizes the pieces come out most-significant first (big endian) or least-significant first (little endian).

The FIFO presents its head long word with a valid flag, in show-ahead style. The matcher shows the current piece combinationally on its read port. An internal piece counter moves forward on each enabled read while data is valid. The enabled read of the final piece raises the pop request to the FIFO in that same cycle, so the FIFO drops the long word at that clock edge. One cycle later a single-cycle done pulse marks the long word as consumed. Port size and byte order are captured while master reset is low. They stay frozen until the next reset.

Top module: `rd_width_matcher`

## Requirements
- R1: While `rst_n` is low, `fifo_pop`, `rd_avail` and `lw_done` are 0. Releasing reset always restarts the piece sequence at the first piece, even when reset arrives partway through a long word.
- R2: With size code 0 (long word), `rd_data` equals `fifo_data` and every enabled read pops.
- R3: With size code 1 (word) and big endian (`big_endian`=1 at reset), the first read returns bits 35..18 and the second returns bits 17..0.
- R4: With size code 1 and little endian, the first read returns bits 17..0 and the second returns bits 35..18.
- R5: With size code 2 (byte) and big endian, the reads return bits 35..27, 26..18, 17..9 and 8..0 in that order.
- R6: With size code 2 and little endian, the reads return bits 8..0, 17..9, 26..18 and 35..27 in that order.
- R7: In word and byte sizes, each piece sits on the low bits of `rd_data` and all higher bits are 0.
- R8: `fifo_pop` is high only in a cycle where `rd_en` and `fifo_valid` are high and the final piece is presented. `rd_last` is high exactly while the final piece is presented.
- R9: When `fifo_valid` is low, `rd_en` is ignored. No pop is issued, `rd_avail` is 0, and the next piece shown once valid returns is the one that was pending.
- R10: Changes on `size_sel` and `big_endian` after reset release have no effect on the piece width or order.
- R11: `lw_done` is high for exactly the one cycle that follows a clock edge at which `fifo_pop` was high.
- R12: Size code 3 behaves as the long-word size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low master reset; captures size and order |
| size_sel | input | 2 | Port size code: 0 long, 1 word, 2 byte, 3 long |
| big_endian | input | 1 | 1 selects most-significant piece first |
| fifo_data | input | 36 | Head long word from the FIFO |
| fifo_valid | input | 1 | FIFO head word is valid |
| fifo_pop | output | 1 | Removes the head long word at this clock edge |
| rd_en | input | 1 | Reader consumes the current piece at this edge |
| rd_data | output | 36 | Current piece, zero-extended |
| rd_avail | output | 1 | A piece is available to read |
| rd_last | output | 1 | The current piece is the final one of the long word |
| lw_done | output | 1 | One-cycle pulse after a long word is consumed |

## Verification
`rd_data`, `rd_last`, `rd_avail` and `fifo_pop` follow the inputs and the piece counter in the same cycle. The bench therefore sets the inputs at the falling edge and samples these outputs a moment later, before the next rising edge. The piece counter moves at the rising edge, so the next piece is checked at the following falling edge. `lw_done` sits one register behind the pop, so it is checked at the first falling edge after the rising edge that popped, and again one cycle later to confirm that it has dropped. Configuration is captured during reset, so each mode is entered through its own reset. The size and order inputs are then scrambled before any read.

// File: rtl/rd_width_matcher.sv
module rd_width_matcher #(
  parameter int LW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    size_sel,
  input  logic          big_endian,
  input  logic [LW-1:0] fifo_data,
  input  logic          fifo_valid,
  output logic          fifo_pop,
  input  logic          rd_en,
  output logic [LW-1:0] rd_data,
  output logic          rd_avail,
  output logic          rd_last,
  output logic          lw_done
);
  localparam int HW = LW / 2;
  localparam int QW = LW / 4;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_BYTE = 2'd2;

  logic [1:0] size_q;
  logic       be_q;
  logic [1:0] cnt;
  logic [1:0] last_idx;
  logic [1:0] slot;
  logic       take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= size_sel;
      be_q   <= big_endian;
    end
  end

  assign last_idx = (size_q == SZ_BYTE) ? 2'd3 : (size_q == SZ_WORD) ? 2'd1 : 2'd0;
  assign rd_last  = (cnt == last_idx);
  assign rd_avail = rst_n && fifo_valid;
  assign take     = rd_avail && rd_en;
  assign fifo_pop = take && rd_last;
  assign slot     = be_q ? (last_idx - cnt) : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      lw_done <= 1'b0;
    end else begin
      lw_done <= fifo_pop;
      if (take) cnt <= rd_last ? 2'd0 : cnt + 2'd1;
    end
  end

  always_comb begin
    rd_data = '0;
    case (size_q)
      SZ_BYTE: rd_data[QW-1:0] = fifo_data[slot*QW +: QW];
      SZ_WORD: rd_data[HW-1:0] = fifo_data[slot[0]*HW +: HW];
      default: rd_data = fifo_data;
    endcase
  end

  // R8
  pop_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (rd_en && fifo_valid));

  // R11
  done_follows_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> lw_done);

  // R11
  done_only_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lw_done |-> $past(fifo_pop));

  // R9
  stall_holds_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_valid |=> $stable(cnt));

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable({size_q, be_q}));

  // R7
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q == SZ_BYTE || size_q == SZ_WORD) |-> (rd_data[LW-1:HW] == '0));

  // R8
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_idx);
endmodule

// File: tb/sim_rd_width_matcher.sv
module sim_rd_width_matcher;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 36;
  localparam logic [8:0] B3 = 9'h1A5, B2 = 9'h0C3, B1 = 9'h15A, B0 = 9'h03C;
  localparam logic [35:0] LWORD = {B3, B2, B1, B0};
  localparam logic [35:0] HI = 36'({B3, B2});
  localparam logic [35:0] LO = 36'({B1, B0});
  localparam int NV = 6;
  // {size, big_endian}
  localparam logic [2:0] CFG [NV] = '{3'b001, 3'b011, 3'b010, 3'b101, 3'b100, 3'b110};
  localparam int NP [NV] = '{1, 2, 2, 4, 4, 1};
  localparam logic [35:0] EXP [NV][4] = '{
    '{LWORD, 36'd0, 36'd0, 36'd0},
    '{HI, LO, 36'd0, 36'd0},
    '{LO, HI, 36'd0, 36'd0},
    '{36'(B3), 36'(B2), 36'(B1), 36'(B0)},
    '{36'(B0), 36'(B1), 36'(B2), 36'(B3)},
    '{LWORD, 36'd0, 36'd0, 36'd0}};
  localparam string REQ [NV] = '{"R2", "R3", "R4", "R5", "R6", "R12"};

  logic clk = 0, rst_n = 0, big_endian = 0, fifo_valid = 0, rd_en = 0;
  logic [1:0] size_sel = 0;
  logic [LW-1:0] fifo_data = '0;
  logic fifo_pop, rd_avail, rd_last, lw_done;
  logic [LW-1:0] rd_data;
  int n_chk = 0, n_fail = 0;

  rd_width_matcher #(.LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .big_endian(big_endian),
    .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fifo_pop(fifo_pop),
    .rd_en(rd_en), .rd_data(rd_data), .rd_avail(rd_avail),
    .rd_last(rd_last), .lw_done(lw_done));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] s, input logic b);
    @(negedge clk);
    rst_n = 0; size_sel = s; big_endian = b;
    rd_en = 1; fifo_valid = 1; fifo_data = LWORD;
    @(negedge clk); #1;
    chk("R1 pop in reset", 36'(fifo_pop), 36'd0);
    chk("R1 avail in reset", 36'(rd_avail), 36'd0);
    chk("R1 done in reset", 36'(lw_done), 36'd0);
    @(negedge clk);
    rst_n = 1; rd_en = 0;
    size_sel = ~s; big_endian = ~b;  // R10: scrambled after release
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      do_reset(CFG[v][2:1], CFG[v][0]);
      for (int w = 0; w < 2; w++) begin
        for (int k = 0; k < NP[v]; k++) begin
          @(negedge clk);
          rd_en = 1; #1;
          chk({REQ[v], " R10 R7 piece"}, rd_data, EXP[v][k]);
          chk("R8 pop on final piece only", 36'(fifo_pop), 36'(k == NP[v] - 1));
          chk("R8 rd_last", 36'(rd_last), 36'(k == NP[v] - 1));
        end
        @(negedge clk);
        rd_en = 0; #1;
        chk("R11 done pulse", 36'(lw_done), 36'd1);
        @(negedge clk); #1;
        chk("R11 done drops", 36'(lw_done), 36'd0);
      end
    end

    // R9: stall in byte big-endian mode
    do_reset(2'd2, 1'b1);
    @(negedge clk); rd_en = 1; #1;
    chk("R5 first byte", rd_data, 36'(B3));
    @(negedge clk); fifo_valid = 0; #1;
    chk("R9 avail low", 36'(rd_avail), 36'd0);
    chk("R9 no pop", 36'(fifo_pop), 36'd0);
    @(negedge clk); #1;
    chk("R9 no pop again", 36'(fifo_pop), 36'd0);
    @(negedge clk); fifo_valid = 1; rd_en = 0; #1;
    chk("R9 pending piece", rd_data, 36'(B2));
    chk("R11 no done without pop", 36'(lw_done), 36'd0);
    @(negedge clk); rd_en = 1; #1;
    chk("R5 second byte", rd_data, 36'(B2));
    @(negedge clk); rd_en = 0; #1;
    chk("R5 third byte", rd_data, 36'(B1));

    // R1: reset mid long word restarts sequence
    do_reset(2'd2, 1'b1);
    @(negedge clk); #1;
    chk("R1 restart at first piece", rd_data, 36'(B3));
    chk("R1 not last", 36'(rd_last), 36'd0);
    chk("R1 done low", 36'(lw_done), 36'd0);

    // R4 with fresh data after reset: new word pieces
    do_reset(2'd1, 1'b0);
    @(negedge clk); fifo_data = 36'hF_0F0F_1234; rd_en = 1; #1;
    chk("R4 low half first", rd_data, 36'h0_0000_1234 | 36'(18'h31234 & 18'h3FFFF) & 36'h3FFFF);
    @(negedge clk); #1;
    chk("R4 high half second", rd_data, 36'(36'hF_0F0F_1234 >> 18));
    chk("R8 pop on second", 36'(fifo_pop), 36'd1);
    @(negedge clk); rd_en = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule